// File: doc/BRIEF.md
# Mode-Latched Configuration Register Unit

This unit holds a microcontroller's operating mode and a handful of system-option bits that depend on it. While reset is held, two mode-select pins are captured into a four-state mode machine. The captured mode sets the reset value of each option bit. It also decides which bits software may rewrite and how often, and how each bit reaches the chip's control pins. The CPU reaches the unit through one 8-bit register. A write happens on a clock edge where chip select and write enable are both high. Reads are combinational while chip select is high.

The mode machine has four states: MODE_SINGLE (single-chip), MODE_EXPANDED (expanded bus), MODE_BOOT (bootstrap) and MODE_TEST (special test). MODE_BOOT and MODE_TEST are the special modes. A register write can cause these transitions:
- BOOT<->TEST: rewrite the alternate bit while the special bit stays 1.
- BOOT->SINGLE and TEST->EXPANDED: clear the special bit.
- BOOT->EXPANDED and TEST->SINGLE: clear the special bit and change the alternate bit in the same write.
- SINGLE<->EXPANDED: rewrite the alternate bit. In the normal modes this is allowed only on the first write after reset.

No write ever moves a normal mode back into a special mode. Reset enters the state selected by the pins.

The unit drives four control outputs:
- a boot-ROM map enable, which maps the boot ROM at $BE00-$BFFF;
- an internal-read echo enable, which drives internal read data out on the external data bus;
- an E-clock output enable;
- a short high-drive enable for the open-drain instruction-fetch pin.

Top module: `mode_cfg_unit`

## Requirements
- R1: Reset is synchronous and active low. On every clock edge with reset low, the pins {cfg_pin_hi,cfg_pin_lo} are captured: 10 gives single-chip, 11 expanded, 00 bootstrap, 01 special test. The special bit (register bit 4) resets to the inverse of cfg_pin_hi. The alternate bit (bit 2) resets to cfg_pin_lo. After reset is released, the pins have no further effect.
- R2: The register reads as: bit 7 = boost bit, bit 6 = boot-ROM bit, bit 4 = special bit, bit 3 = echo/E bit, bit 2 = alternate bit. Bits 5, 1 and 0 always read 0. rd_data is 0 while cfg_cs is low.
- R3: A write can only clear the special bit, and only while it is 1. Once the special bit is 0, no write sets it again.
- R4: In a special mode the alternate bit takes every written value. In a normal mode only the first write after reset updates it; later writes leave it unchanged.
- R5: The boot-ROM bit resets to 1 in bootstrap mode and to 0 in every other mode. It is written only while the special bit is 1. bootrom_map_en equals boot-ROM bit AND special bit.
- R6: The echo/E bit resets to 1 in special test mode and to 0 in every other mode. It is writable at any time in a special mode, but only by the first write after reset in a normal mode.
- R7: rd_echo_en equals echo/E bit AND alternate bit, so it is active only in expanded or special test mode.
- R8: eclk_out_en is 1 whenever the alternate bit is 1. When the alternate bit is 0, it is the inverse of the echo/E bit.
- R9: The boost bit resets to 0 and follows the same write rules as R6. fetch_pin_boost_en equals boost bit AND alternate bit, so it stays 0 in single-chip and bootstrap modes.
- R10: Reset clears every write-once lock. A write's effect shows on rd_data and on the outputs right after the clock edge that accepts it.
- R11: A clock edge with cfg_cs or cfg_we low changes no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode pins are captured while it is low |
| cfg_pin_hi | input | 1 | Mode-select pin, upper bit |
| cfg_pin_lo | input | 1 | Mode-select pin, lower bit |
| cfg_cs | input | 1 | Register address decode strobe |
| cfg_we | input | 1 | Write enable, qualified by cfg_cs |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational while cfg_cs is high |
| bootrom_map_en | output | 1 | Boot ROM mapped at $BE00-$BFFF |
| rd_echo_en | output | 1 | Drive internal read data onto the external bus |
| eclk_out_en | output | 1 | Drive the E clock out (0 holds the E pin low) |
| fetch_pin_boost_en | output | 1 | Allow the quarter-cycle high drive of the fetch pin |

## Verification
Every result is registered once and then decoded combinationally. The reset values therefore appear after the first clock edge that has reset low. A write appears on rd_data and on all four outputs after the single edge that accepts it. The bench changes its inputs on falling edges and samples 1 ns after setting up a read, so each check lands in the half-cycle right after the edge that produced the value. For every mode and every 8-bit first-write value, the bench checks the reset image, the first write, the complemented second write and an unselected write.

// File: rtl/mcfg_pkg.sv
package mcfg_pkg;

    // Mode encoding matches the captured pins {hi, lo}
    typedef enum logic [1:0] {
        MODE_BOOT     = 2'b00,
        MODE_TEST     = 2'b01,
        MODE_SINGLE   = 2'b10,
        MODE_EXPANDED = 2'b11
    } op_mode_e;

    localparam int BIT_BOOST   = 7;
    localparam int BIT_BOOTROM = 6;
    localparam int BIT_NIL     = 5;
    localparam int BIT_SPEC    = 4;
    localparam int BIT_ECHO    = 3;
    localparam int BIT_ALT     = 2;

    function automatic logic mode_special(input op_mode_e m);
        return ~m[1];
    endfunction

    function automatic logic mode_alt(input op_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/mcfg_mode_fsm.sv
module mcfg_mode_fsm
    import mcfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_hi,
    input  logic     pin_lo,
    input  logic     wr_stb,
    input  logic     wr_spec,
    input  logic     wr_alt,
    output op_mode_e mode_q
);

    op_mode_e mode_d;
    logic     alt_lock_q;
    logic     alt_lock_d;
    logic     spec_now;

    assign spec_now = mode_special(mode_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= op_mode_e'({pin_hi, pin_lo});
            alt_lock_q <= 1'b0;
        end else begin
            mode_q     <= mode_d;
            alt_lock_q <= alt_lock_d;
        end
    end

    // next state
    always_comb begin
        mode_d     = mode_q;
        alt_lock_d = alt_lock_q;
        unique case (mode_q)
            MODE_BOOT, MODE_TEST: begin
                if (wr_stb) begin
                    if (wr_spec)
                        mode_d = wr_alt ? MODE_TEST : MODE_BOOT;
                    else
                        mode_d = wr_alt ? MODE_EXPANDED : MODE_SINGLE;
                end
            end
            MODE_SINGLE, MODE_EXPANDED: begin
                if (wr_stb) begin
                    alt_lock_d = 1'b1;
                    if (!alt_lock_q)
                        mode_d = wr_alt ? MODE_EXPANDED : MODE_SINGLE;
                end
            end
        endcase
    end

    // R3
    no_respecial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spec_now |=> !mode_special(mode_q));

    // R4
    alt_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_now && alt_lock_q) |=> $stable(mode_q));

endmodule

// File: rtl/mcfg_once_bit.sv
module mcfg_once_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_val,
    input  logic special,
    input  logic wr_stb,
    input  logic wr_bit,
    output logic bit_q
);

    logic lock_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= rst_val;
            lock_q <= 1'b0;
        end else if (wr_stb) begin
            if (special || !lock_q)
                bit_q <= wr_bit;
            if (!special)
                lock_q <= 1'b1;
        end
    end

    // R6 R9
    once_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!special && lock_q) |=> $stable(bit_q));

    // R10
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !special) |=> lock_q);

endmodule

// File: rtl/mode_cfg_unit.sv
module mode_cfg_unit
    import mcfg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_pin_hi,
    input  logic              cfg_pin_lo,
    input  logic              cfg_cs,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              bootrom_map_en,
    output logic              rd_echo_en,
    output logic              eclk_out_en,
    output logic              fetch_pin_boost_en
);

    localparam int N_ONCE = 2;
    localparam int ONCE_POS [N_ONCE] = '{BIT_BOOST, BIT_ECHO};

    op_mode_e          mode_q;
    logic              wr_stb;
    logic              spec;
    logic              alt;
    logic              bootrom_q;
    logic [N_ONCE-1:0] once_q;
    logic [N_ONCE-1:0] once_rst;
    logic [DATA_W-1:0] image;

    assign wr_stb = cfg_cs & cfg_we;
    assign spec   = mode_special(mode_q);
    assign alt    = mode_alt(mode_q);

    mcfg_mode_fsm u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_hi  (cfg_pin_hi),
        .pin_lo  (cfg_pin_lo),
        .wr_stb  (wr_stb),
        .wr_spec (wr_data[BIT_SPEC]),
        .wr_alt  (wr_data[BIT_ALT]),
        .mode_q  (mode_q)
    );

    for (genvar g = 0; g < N_ONCE; g++) begin : g_once
        if (ONCE_POS[g] == BIT_ECHO) begin : g_echo
            assign once_rst[g] = ({cfg_pin_hi, cfg_pin_lo} == MODE_TEST);
        end else begin : g_zero
            assign once_rst[g] = 1'b0;
        end
        mcfg_once_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .rst_val (once_rst[g]),
            .special (spec),
            .wr_stb  (wr_stb),
            .wr_bit  (wr_data[ONCE_POS[g]]),
            .bit_q   (once_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            bootrom_q <= ({cfg_pin_hi, cfg_pin_lo} == MODE_BOOT);
        else if (wr_stb && spec)
            bootrom_q <= wr_data[BIT_BOOTROM];
    end

    // output decode
    always_comb begin
        image              = '0;
        image[BIT_BOOST]   = once_q[0];
        image[BIT_BOOTROM] = bootrom_q;
        image[BIT_SPEC]    = spec;
        image[BIT_ECHO]    = once_q[1];
        image[BIT_ALT]     = alt;
        rd_data            = cfg_cs ? image : '0;
        bootrom_map_en     = bootrom_q & spec;
        rd_echo_en         = once_q[1] & alt;
        eclk_out_en        = alt | ~once_q[1];
        fetch_pin_boost_en = once_q[0] & alt;
    end

    // R5
    bootrom_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spec |=> $stable(bootrom_q));

    // R1 R6 R10
    rst_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (bootrom_q == (mode_q == MODE_BOOT)) &&
                         (once_q[1] == (mode_q == MODE_TEST)) && !once_q[0]);

endmodule

// File: tb/test_mode_cfg_unit.sv
module test_mode_cfg_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_hi = 1'b0, pin_lo = 1'b0;
    logic       cs = 1'b0, we = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rd;
    logic       o_boot, o_echo, o_eclk, o_boost;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    // requirement-level model
    bit m_spec, m_alt, m_boot, m_echo, m_boost;
    bit lk_alt, lk_echo, lk_boost;

    always #10 clk = ~clk;

    mode_cfg_unit i_mode_cfg_unit (
        .clk(clk), .rst_n(rst_n), .cfg_pin_hi(pin_hi), .cfg_pin_lo(pin_lo),
        .cfg_cs(cs), .cfg_we(we), .wr_data(wd), .rd_data(rd),
        .bootrom_map_en(o_boot), .rd_echo_en(o_echo), .eclk_out_en(o_eclk),
        .fetch_pin_boost_en(o_boost)
    );

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string phase);
        logic [7:0] img;
        img = {m_boost, m_boot, 1'b0, m_spec, m_echo, m_alt, 2'b00};
        cs = 1'b1; we = 1'b0;
        #1;
        cmp({"R2 image ", phase}, rd, img);
        cmp({"R5 bootrom_map_en ", phase}, {7'd0, o_boot}, {7'd0, m_boot & m_spec});
        cmp({"R7 rd_echo_en ", phase}, {7'd0, o_echo}, {7'd0, m_echo & m_alt});
        cmp({"R8 eclk_out_en ", phase}, {7'd0, o_eclk}, {7'd0, m_alt | ~m_echo});
        cmp({"R9 fetch_pin_boost_en ", phase}, {7'd0, o_boost}, {7'd0, m_boost & m_alt});
        cs = 1'b0;
        #1;
        cmp({"R2 deselected read ", phase}, rd, 8'h00);
    endtask

    task automatic do_reset(input bit hi, input bit lo);
        @(negedge clk);
        rst_n = 1'b0; pin_hi = hi; pin_lo = lo;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pin_hi = ~hi; pin_lo = ~lo;   // R1: pins ignored after reset
        m_spec = ~hi; m_alt = lo;
        m_boot = ({hi, lo} == 2'b00);
        m_echo = ({hi, lo} == 2'b01);
        m_boost = 1'b0;
        lk_alt = 0; lk_echo = 0; lk_boost = 0;
    endtask

    task automatic do_write(input logic [7:0] d);
        bit normal;
        @(negedge clk);
        cs = 1'b1; we = 1'b1; wd = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
        normal = ~m_spec;
        if (m_spec) m_boot = d[6];
        if (m_spec || !lk_alt)   m_alt   = d[2];
        if (m_spec || !lk_echo)  m_echo  = d[3];
        if (m_spec || !lk_boost) m_boost = d[7];
        m_spec = m_spec & d[4];
        if (normal) begin lk_alt = 1; lk_echo = 1; lk_boost = 1; end
    endtask

    task automatic idle_write(input logic [7:0] d);
        @(negedge clk);
        cs = 1'b0; we = 1'b1; wd = d;
        @(negedge clk);
        cs = 1'b1; we = 1'b0; wd = ~d;
        @(negedge clk);
        cs = 1'b0;
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 256; v++) begin
                do_reset(m[1], m[0]);
                check_all("R1/R6/R10 reset values");
                do_write(v[7:0]);
                check_all("R3/R4/R5/R6/R9 first write");
                do_write(~v[7:0]);
                check_all("R3/R4/R6/R10 second write");
                idle_write(v[7:0] ^ 8'h5A);
                check_all("R11 unselected write");
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule